// File: doc/BRIEF.md
# Port Source Address Security Filter

This unit sits beside the receive side of a multiport repeater. At the end of every packet the receive logic gives it a summary: the port the packet came in on, its 48-bit source and destination addresses, a CRC-good flag and a one-cycle end-of-packet strobe. Each port owns a store with two address entries. While learning is enabled on a port, the unit fills those entries from the source addresses of good packets. Once software starts comparison, the unit checks later packets against the entries that hold a valid address.

For each packet the unit decides, one cycle after end of packet, whether the repeater should replace the outgoing data with a pseudo-random pattern (scramble-select). It also decides whether to send a mismatch pulse, tagged with the port number, to the hub manager. A global pass-intact option lets packets with a source mismatch go through unchanged while they are still reported. A small register port gives the processor access to each port's security bits and entries and to the global option. In secure mode, access to a port's entries is locked out while that port is learning.

A strap input selects secure or non-secure operation. It also sets the reset value of the per-port enables. In non-secure mode learning still works, but the unit never compares addresses and never locks out the processor.

Top module: `psa_filter`

## Requirements
- R1: In reset, and right after it, every port's control word is 0x0F when `mode_nonsec`=0 and 0x00 when `mode_nonsec`=1. Both valid bits and the start bit are 0, the global word reads 0, the outputs are low, and `rand_data` holds 0xACE1.
- R2: With learn-enable set, the source address of the first CRC-good packet on a port with no valid entry is written to entry 0, and control bit 5 (valid 0) is set.
- R3: Once entry 0 is valid, a CRC-good packet fills entry 1 and sets control bit 6 (valid 1) only if its source address differs from entry 0. A repeat of the entry-0 address changes nothing.
- R4: A packet whose CRC flag is low never writes an entry and never sets a valid bit.
- R5: Learning happens only while control bit 0 (learn-enable) is 1, and it happens in secure and non-secure mode alike.
- R6: A packet is compared only when `mode_nonsec`=0, control bit 4 (start) is 1, control bit 1 (check-enable) is 1 and at least one valid bit is set. Only entries whose valid bit is 1 take part. When no compare takes place, the flag and scramble-select stay low.
- R7: With control bit 2 (source-enable) set, a source address that matches no valid entry raises the flag. It also raises scramble-select when global bit 0 (pass-intact) is 0, and leaves it low when pass-intact is 1.
- R8: With control bit 3 (destination-enable) set, a destination address that matches no valid entry of the receiving port raises both the flag and scramble-select, whatever the pass-intact setting.
- R9: When `mode_nonsec`=0 and a port is learning (learn-enable is 1 and not both entries are valid), reads of that port's entries return 0. A write to an entry is held back, and it is applied in the cycle after learning ends, setting that entry's valid bit. In non-secure mode, entry accesses act at once.
- R10: `mm_flag` is a single-cycle pulse in the cycle after the end-of-packet strobe, and `mm_port` then carries that packet's port number.
- R11: `rand_data` steps every cycle as a 16-bit shift register: it shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It is never zero.
- R12: Register map, selected by `reg_sel`. 0 is the control word of port `reg_port`: bit0 learn-enable, bit1 check-enable, bit2 source-enable, bit3 destination-enable, bit4 start, bit5 valid 0, bit6 valid 1, and a write replaces all seven bits. 1 is entry 0 and 2 is entry 1; a write to either sets that entry's valid bit. 3 is the global word, whose bit0 is pass-intact. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_nonsec | input | 1 | Strap: 1 selects non-secure operation |
| pkt_eop | input | 1 | End-of-packet strobe, one cycle |
| pkt_port | input | PORT_W | Port the packet arrived on |
| pkt_sa | input | ADDR_W | Packet source address |
| pkt_da | input | ADDR_W | Packet destination address |
| pkt_crc_ok | input | 1 | Packet CRC was good |
| reg_wr | input | 1 | Register write strobe |
| reg_port | input | PORT_W | Port addressed by the register access |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data |
| scram_sel | output | 1 | Replace this packet's data with the random pattern |
| mm_flag | output | 1 | Mismatch pulse to the hub manager |
| mm_port | output | PORT_W | Port of the reported mismatch |
| rand_data | output | 16 | Pseudo-random replacement pattern |

## Verification
The bench sweeps every port through the combinations of source hit in entry 0, hit in entry 1 or miss, destination hit or miss, destination-enable and pass-intact. A design that ignored pass-intact, or let it mask destination misses, would give the wrong scramble-select. Learning is driven with a bad-CRC packet and with a repeat of the first address. A design that learned either would fill an entry early, which shows in the valid bits. Lockout is checked in two ways: entry reads during learning must return zero, and a held write must land exactly one cycle after learning is turned off. A design that wrote at once, dropped the write or applied it late would be caught. Valid-bit gating, the start and check bits, and non-secure mode are each set up so that a miss would report a wrong mismatch.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int unsigned MAC_W   = 48;
  localparam int unsigned RAND_W  = 16;
  localparam logic [RAND_W-1:0] RAND_SEED = 16'hACE1;
  localparam logic [RAND_W-1:0] RAND_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ENT0 = 2'd1,
    SEL_ENT1 = 2'd2,
    SEL_GLOB = 2'd3
  } rsel_e;

  typedef struct packed {
    logic start;
    logic da_en;
    logic sa_en;
    logic chk_en;
    logic learn_en;
  } sec_cfg_t;

  function automatic logic parity_of(input logic [RAND_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/psa_lfsr.sv
module psa_lfsr
  import psa_pkg::*;
#(
  parameter int unsigned W = RAND_W,
  parameter logic [W-1:0] SEED = RAND_SEED,
  parameter logic [W-1:0] TAPS = RAND_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/psa_port_slot.sv
module psa_port_slot
  import psa_pkg::*;
#(
  parameter int unsigned AW = MAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          secure,
  input  logic          eop_hit,
  input  logic          crc_ok,
  input  logic [AW-1:0] sa,
  input  logic          wr_hit,
  input  rsel_e         wsel,
  input  logic [AW-1:0] wdata,
  output sec_cfg_t      cfg,
  output logic [1:0]    adv,
  output logic [AW-1:0] ent0,
  output logic [AW-1:0] ent1,
  output logic          lock,
  output logic          learn_evt
);
  logic learning, entry_wr, hold_req, held_apply;
  logic learn0, learn1;
  logic pend_v, pend_sel;
  logic [AW-1:0] pend_dat;

  // learning lasts until both entries hold an address or learn-enable drops
  assign learning   = cfg.learn_en && !(adv[0] && adv[1]);
  assign lock       = secure && learning;
  assign entry_wr   = wr_hit && (wsel == SEL_ENT0 || wsel == SEL_ENT1);
  assign hold_req   = entry_wr && lock;
  assign held_apply = pend_v && !lock;

  assign learn0    = eop_hit && crc_ok && cfg.learn_en && !adv[0];
  assign learn1    = eop_hit && crc_ok && cfg.learn_en && adv[0] && !adv[1]
                     && (sa != ent0);
  assign learn_evt = learn0 || learn1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= sec_cfg_t'({1'b0, {4{secure}}});
      adv      <= '0;
      ent0     <= '0;
      ent1     <= '0;
      pend_v   <= 1'b0;
      pend_sel <= 1'b0;
      pend_dat <= '0;
    end else begin
      if (held_apply) begin
        pend_v <= 1'b0;
        if (pend_sel) begin
          ent1   <= pend_dat;
          adv[1] <= 1'b1;
        end else begin
          ent0   <= pend_dat;
          adv[0] <= 1'b1;
        end
      end
      if (wr_hit && wsel == SEL_CTRL) begin
        cfg <= sec_cfg_t'(wdata[4:0]);
        adv <= wdata[6:5];
      end
      if (entry_wr && !lock) begin
        if (wsel == SEL_ENT1) begin
          ent1   <= wdata;
          adv[1] <= 1'b1;
        end else begin
          ent0   <= wdata;
          adv[0] <= 1'b1;
        end
      end
      if (hold_req) begin
        pend_v   <= 1'b1;
        pend_sel <= (wsel == SEL_ENT1);
        pend_dat <= wdata;
      end
      if (learn0) begin
        ent0   <= sa;
        adv[0] <= 1'b1;
      end
      if (learn1) begin
        ent1   <= sa;
        adv[1] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/psa_decide.sv
module psa_decide
  import psa_pkg::*;
#(
  parameter int unsigned AW = MAC_W
) (
  input  logic          secure,
  input  logic          pass_intact,
  input  sec_cfg_t      cfg,
  input  logic [1:0]    adv,
  input  logic [AW-1:0] ent0,
  input  logic [AW-1:0] ent1,
  input  logic [AW-1:0] sa,
  input  logic [AW-1:0] da,
  output logic          sa_miss,
  output logic          da_miss,
  output logic          flag,
  output logic          scram
);
  function automatic logic known(input logic [AW-1:0] a, input logic [AW-1:0] e0,
                                 input logic [AW-1:0] e1, input logic [1:0] v);
    return (v[0] && a == e0) || (v[1] && a == e1);
  endfunction

  logic cmp_on;
  assign cmp_on  = secure && cfg.start && cfg.chk_en && (adv != 2'b00);
  assign sa_miss = cmp_on && cfg.sa_en && !known(sa, ent0, ent1, adv);
  assign da_miss = cmp_on && cfg.da_en && !known(da, ent0, ent1, adv);
  assign flag    = sa_miss || da_miss;
  assign scram   = da_miss || (sa_miss && !pass_intact);
endmodule

// File: rtl/psa_filter.sv
module psa_filter
  import psa_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = MAC_W,
  localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_nonsec,
  input  logic              pkt_eop,
  input  logic [PORT_W-1:0] pkt_port,
  input  logic [ADDR_W-1:0] pkt_sa,
  input  logic [ADDR_W-1:0] pkt_da,
  input  logic              pkt_crc_ok,
  input  logic              reg_wr,
  input  logic [PORT_W-1:0] reg_port,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              scram_sel,
  output logic              mm_flag,
  output logic [PORT_W-1:0] mm_port,
  output logic [RAND_W-1:0] rand_data
);
  logic secure;
  assign secure = ~mode_nonsec;

  rsel_e sel;
  assign sel = rsel_e'(reg_sel);

  sec_cfg_t          cfg_a  [NUM_PORTS];
  logic [1:0]        adv_a  [NUM_PORTS];
  logic [ADDR_W-1:0] ent0_a [NUM_PORTS];
  logic [ADDR_W-1:0] ent1_a [NUM_PORTS];
  logic [NUM_PORTS-1:0] lock_v, learn_v;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    psa_port_slot #(.AW(ADDR_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .secure    (secure),
      .eop_hit   (pkt_eop && pkt_port == PORT_W'(g)),
      .crc_ok    (pkt_crc_ok),
      .sa        (pkt_sa),
      .wr_hit    (reg_wr && reg_port == PORT_W'(g)),
      .wsel      (sel),
      .wdata     (reg_wdata),
      .cfg       (cfg_a[g]),
      .adv       (adv_a[g]),
      .ent0      (ent0_a[g]),
      .ent1      (ent1_a[g]),
      .lock      (lock_v[g]),
      .learn_evt (learn_v[g])
    );
  end

  // events brought out for the checker
  logic learn_any, rd_lock;
  assign learn_any = |learn_v;
  assign rd_lock   = lock_v[reg_port];

  logic pass_intact;
  logic d_sa_miss, d_da_miss, d_flag, d_scram;

  psa_decide #(.AW(ADDR_W)) u_decide (
    .secure      (secure),
    .pass_intact (pass_intact),
    .cfg         (cfg_a[pkt_port]),
    .adv         (adv_a[pkt_port]),
    .ent0        (ent0_a[pkt_port]),
    .ent1        (ent1_a[pkt_port]),
    .sa          (pkt_sa),
    .da          (pkt_da),
    .sa_miss     (d_sa_miss),
    .da_miss     (d_da_miss),
    .flag        (d_flag),
    .scram       (d_scram)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: reg_rdata = ADDR_W'({adv_a[reg_port], cfg_a[reg_port]});
      SEL_ENT0: reg_rdata = rd_lock ? '0 : ent0_a[reg_port];
      SEL_ENT1: reg_rdata = rd_lock ? '0 : ent1_a[reg_port];
      default:  reg_rdata = ADDR_W'(pass_intact);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scram_sel   <= 1'b0;
      mm_flag     <= 1'b0;
      mm_port     <= '0;
      pass_intact <= 1'b0;
    end else begin
      scram_sel <= pkt_eop && d_scram;
      mm_flag   <= pkt_eop && d_flag;
      if (pkt_eop) mm_port <= pkt_port;
      if (reg_wr && sel == SEL_GLOB) pass_intact <= reg_wdata[0];
    end
  end

  psa_lfsr u_rand (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (rand_data)
  );
endmodule

// File: rtl/psa_filter_chk.sv
module psa_filter_chk #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned PORT_W = 2,
  parameter int unsigned RW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_nonsec,
  input logic              pkt_eop,
  input logic [PORT_W-1:0] pkt_port,
  input logic [1:0]        reg_sel,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic              scram_sel,
  input logic              mm_flag,
  input logic [PORT_W-1:0] mm_port,
  input logic [RW-1:0]     rand_data,
  input logic              rd_lock
);
  a_r9_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && (reg_sel == 2'd1 || reg_sel == 2'd2)) |-> reg_rdata == '0);

  a_r10_flag_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    mm_flag |-> ($past(pkt_eop) && mm_port == $past(pkt_port)));

  a_r6_nonsec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_nonsec |-> (!mm_flag && !scram_sel));

  a_r7_scram_reported: assert property (@(posedge clk) disable iff (!rst_n)
    scram_sel |-> mm_flag);

  a_r11_rand_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rand_data != '0);
endmodule

bind psa_filter psa_filter_chk #(
  .ADDR_W (ADDR_W),
  .PORT_W (PORT_W),
  .RW     (psa_pkg::RAND_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_nonsec (mode_nonsec),
  .pkt_eop     (pkt_eop),
  .pkt_port    (pkt_port),
  .reg_sel     (reg_sel),
  .reg_rdata   (reg_rdata),
  .scram_sel   (scram_sel),
  .mm_flag     (mm_flag),
  .mm_port     (mm_port),
  .rand_data   (rand_data),
  .rd_lock     (rd_lock)
);

// File: tb/psa_filter_test.sv
module psa_filter_test;
  localparam int NP = 4;
  localparam int AW = 48;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, mode_nonsec, pkt_eop, pkt_crc_ok, reg_wr;
  logic [1:0]    pkt_port, reg_port, reg_sel;
  logic [AW-1:0] pkt_sa, pkt_da, reg_wdata, reg_rdata;
  logic          scram_sel, mm_flag;
  logic [1:0]    mm_port;
  logic [15:0]   rand_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  psa_filter #(.NUM_PORTS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_nonsec(mode_nonsec),
    .pkt_eop(pkt_eop), .pkt_port(pkt_port), .pkt_sa(pkt_sa), .pkt_da(pkt_da),
    .pkt_crc_ok(pkt_crc_ok), .reg_wr(reg_wr), .reg_port(reg_port),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scram_sel(scram_sel), .mm_flag(mm_flag), .mm_port(mm_port),
    .rand_data(rand_data)
  );

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mac(input int p, input int k);
    return {8'h02, 8'(k), 24'h0, 8'(p)};
  endfunction

  function automatic logic [15:0] rstep(input logic [15:0] s);
    logic nb;
    nb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return (s << 1) | 16'(nb);
  endfunction

  // every task starts and ends just after a falling edge
  task automatic wreg(input int p, input int s, input logic [AW-1:0] d);
    reg_wr = 1'b1; reg_port = 2'(p); reg_sel = 2'(s); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input int p, input int s, output logic [AW-1:0] d);
    reg_port = 2'(p); reg_sel = 2'(s);
    #1 d = reg_rdata;
  endtask

  task automatic send(input int p, input logic [AW-1:0] sa, input logic [AW-1:0] da,
                      input bit crc, output bit scr, output bit flg, output int prt);
    pkt_eop = 1'b1; pkt_port = 2'(p); pkt_sa = sa; pkt_da = da; pkt_crc_ok = crc;
    @(negedge clk);
    pkt_eop = 1'b0;
    scr = scram_sel; flg = mm_flag; prt = int'(mm_port);
  endtask

  task automatic do_reset(input bit nonsec);
    rst_n = 1'b0; mode_nonsec = nonsec;
    repeat (3) @(negedge clk);
    chk_eq("R1 random seed in reset", 64'(rand_data), 64'h0ACE1);
    chk_eq("R1 flag low in reset", 64'(mm_flag), 64'd0);
    chk_eq("R1 scramble low in reset", 64'(scram_sel), 64'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] d;
    logic [15:0] prev;
    bit s, f;
    int pt;
    pkt_eop = 0; pkt_port = 0; pkt_sa = 0; pkt_da = 0; pkt_crc_ok = 0;
    reg_wr = 0; reg_port = 0; reg_sel = 0; reg_wdata = 0;
    @(negedge clk);

    // ---------------- secure mode ----------------
    do_reset(1'b0);
    prev = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      chk_eq("R11 random step", 64'(rand_data), 64'(rstep(prev)));
      prev = rand_data;
    end
    for (int p = 0; p < NP; p++) begin
      rreg(p, 0, d); chk_eq("R1 R12 secure control reset", 64'(d), 64'h0F);
    end
    rreg(0, 3, d); chk_eq("R1 R12 global reset", 64'(d), 64'h0);

    // learning on every port
    for (int p = 0; p < NP; p++) begin
      send(p, mac(p, 1), mac(p, 9), 1'b0, s, f, pt);
      rreg(p, 0, d); chk_eq("R4 bad CRC not learned", 64'(d), 64'h0F);
      chk_eq("R6 no compare before start", 64'(f), 64'd0);
      send(p, mac(p, 1), mac(p, 9), 1'b1, s, f, pt);
      rreg(p, 0, d); chk_eq("R2 first address valid", 64'(d), 64'h2F);
      rreg(p, 1, d); chk_eq("R9 entry read zero while learning", 64'(d), 64'h0);
      send(p, mac(p, 1), mac(p, 9), 1'b1, s, f, pt);
      rreg(p, 0, d); chk_eq("R3 repeat address ignored", 64'(d), 64'h2F);
      send(p, mac(p, 2), mac(p, 9), 1'b0, s, f, pt);
      rreg(p, 0, d); chk_eq("R4 bad CRC second slot", 64'(d), 64'h2F);
      send(p, mac(p, 2), mac(p, 9), 1'b1, s, f, pt);
      rreg(p, 0, d); chk_eq("R3 second address valid", 64'(d), 64'h6F);
      rreg(p, 1, d); chk_eq("R2 entry 0 content", 64'(d), 64'(mac(p, 1)));
      rreg(p, 2, d); chk_eq("R3 entry 1 content", 64'(d), 64'(mac(p, 2)));
    end

    // decision sweep
    for (int pass = 0; pass < 2; pass++) begin
      wreg(0, 3, AW'(pass));
      rreg(0, 3, d); chk_eq("R12 global word", 64'(d), 64'(pass));
      for (int p = 0; p < NP; p++) begin
        for (int den = 0; den < 2; den++) begin
          wreg(p, 0, AW'(den ? 'h7E : 'h76));
          for (int sk = 1; sk <= 3; sk++) begin
            for (int dk = 1; dk <= 3; dk += 2) begin
              bit sam, dam, ef, es;
              sam = (sk == 3);
              dam = (den == 1) && (dk == 3);
              ef  = sam || dam;
              es  = dam || (sam && pass == 0);
              send(p, mac(p, sk), mac(p, dk), 1'b1, s, f, pt);
              chk_eq(dam ? "R8 destination miss scramble" : "R7 scramble select",
                     64'(s), 64'(es));
              chk_eq("R7 R8 mismatch flag", 64'(f), 64'(ef));
              if (ef) chk_eq("R10 flag port", 64'(pt), 64'(p));
              @(negedge clk);
              chk_eq("R10 flag one cycle", 64'(mm_flag), 64'd0);
            end
          end
        end
      end
    end

    // compare gating on port 0
    wreg(0, 3, AW'(0));
    wreg(0, 0, AW'('h66));
    send(0, mac(0, 3), mac(0, 1), 1'b1, s, f, pt);
    chk_eq("R6 start clear no compare", 64'(f), 64'd0);
    wreg(0, 0, AW'('h56));
    send(0, mac(0, 1), mac(0, 1), 1'b1, s, f, pt);
    chk_eq("R6 invalid entry 0 not used", 64'(f), 64'd1);
    send(0, mac(0, 2), mac(0, 1), 1'b1, s, f, pt);
    chk_eq("R6 valid entry 1 used", 64'(f), 64'd0);
    wreg(0, 0, AW'('h16));
    send(0, mac(0, 3), mac(0, 1), 1'b1, s, f, pt);
    chk_eq("R6 no valid entry no compare", 64'(f), 64'd0);
    wreg(0, 0, AW'('h74));
    send(0, mac(0, 3), mac(0, 1), 1'b1, s, f, pt);
    chk_eq("R6 check enable clear", 64'(s) + 64'(f), 64'd0);

    // held write on port 1
    wreg(1, 0, AW'('h0F));
    wreg(1, 2, mac(1, 7));
    rreg(1, 2, d); chk_eq("R9 locked read", 64'(d), 64'h0);
    send(1, mac(1, 4), mac(1, 4), 1'b1, s, f, pt);
    rreg(1, 0, d); chk_eq("R9 held write not applied", 64'(d), 64'h2F);
    wreg(1, 0, AW'('h2E));
    rreg(1, 2, d); chk_eq("R9 held write waits a cycle", 64'(d), 64'(mac(1, 2)));
    @(negedge clk);
    rreg(1, 2, d); chk_eq("R9 held write applied", 64'(d), 64'(mac(1, 7)));
    rreg(1, 0, d); chk_eq("R9 held write sets valid", 64'(d), 64'h6E);
    rreg(1, 1, d); chk_eq("R2 learned while locked", 64'(d), 64'(mac(1, 4)));

    // learn-enable clear on port 2
    wreg(2, 0, AW'('h00));
    send(2, mac(2, 5), mac(2, 5), 1'b1, s, f, pt);
    rreg(2, 0, d); chk_eq("R5 no learning when disabled", 64'(d), 64'h00);

    // ---------------- non-secure mode ----------------
    @(negedge clk);
    do_reset(1'b1);
    for (int p = 0; p < NP; p++) begin
      rreg(p, 0, d); chk_eq("R1 non-secure control reset", 64'(d), 64'h00);
    end
    wreg(0, 0, AW'('h01));
    send(0, mac(0, 6), mac(0, 6), 1'b1, s, f, pt);
    rreg(0, 0, d); chk_eq("R5 learning in non-secure", 64'(d), 64'h21);
    rreg(0, 1, d); chk_eq("R9 no lockout in non-secure", 64'(d), 64'(mac(0, 6)));
    wreg(0, 2, mac(0, 8));
    rreg(0, 2, d); chk_eq("R9 direct write in non-secure", 64'(d), 64'(mac(0, 8)));
    wreg(0, 0, AW'('h36));
    send(0, mac(0, 3), mac(0, 3), 1'b1, s, f, pt);
    chk_eq("R6 no compare in non-secure", 64'(f), 64'd0);
    chk_eq("R6 no scramble in non-secure", 64'(s), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule